// File: doc/BRIEF.md
# Bidirectional Parallel Port Slice with Open-Drain Option

This block is one general-purpose parallel port of a microcontroller. It holds an output data latch and a direction register, and both sit on a small strobe bus with an address, a write strobe and a read strobe. For each pin it drives an output-enable and an output value toward a tristate pad. Pins marked as outputs drive the latched value. Pins marked as inputs stay undriven, and their pad level is synchronized so software can read it back.

A wired-OR control turns the port into open-drain outputs. In that mode a 0 pulls the pin low and a 1 leaves it floating. Two other functions can take over the pins. A timer output-compare function can own single pins. If the port is built as the data-bus port, an expanded bus operating mode takes over the whole port. Ownership changes only what reaches the pad. Register writes keep landing in the latch, so the latched value appears on the pin again once the owner lets go.

Top module: `gport_slice`

## Requirements
- R1: After a synchronous active-low reset, the direction and data registers hold all zeros, every `pad_oe` bit is 0, every `pad_out` bit is 0 and `rdata` is 0.
- R2: A write to address BASE_ADDR always stores `wdata` in the data latch, whatever the direction bits, the mode or the timer ownership. A later read of that address returns the latch bit for every pin whose direction bit is 1.
- R3: A read of address BASE_ADDR returns, for each pin whose direction bit is 0, the `pad_in` level after a two-flop synchronizer. A pad change made before two rising edges have passed is visible to a read strobe sampled at the following edge.
- R4: With no bus takeover, no timer ownership and wired-OR off, `pad_oe` equals the direction register, and `pad_out` equals latch AND direction. `pad_out` is 0 on every undriven pin.
- R5: With wired-OR on and no bus takeover, a driven pin whose value is 0 has `pad_oe`=1 and `pad_out`=0. A driven pin whose value is 1 has `pad_oe`=0. `pad_out` is never 1.
- R6: In the bus port (IS_BUS_PORT=1), `mode` 2'b01 (expanded) and 2'b11 (test) hand every pin to the bus: `pad_oe`=`bus_oe` and `pad_out`=`bus_out` AND `bus_oe`. Wired-OR and timer ownership have no effect there. Wired-OR takes effect only in `mode` 2'b00 (single-chip) and 2'b10 (bootstrap).
- R7: A pin with its `tmr_own` bit set is driven (`pad_oe`=1 with wired-OR off) with its `tmr_val` bit, whatever its direction bit. Writes to the data latch leave that pin unchanged.
- R8: When `tmr_own` for a pin clears, that pin follows its direction bit and the most recently written latch value again.
- R9: A read of address BASE_ADDR+1 returns the direction register. A read of any other address returns 0.
- R10: `rdata` is loaded at the rising edge where `rd_en` is 1 and holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data |
| mode | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| od_en | input | 1 | Wired-OR (open-drain) enable |
| tmr_own | input | WIDTH | Per-pin timer output-compare ownership |
| tmr_val | input | WIDTH | Timer output-compare pin values |
| bus_oe | input | WIDTH | Bus output-enable when the bus owns the port |
| bus_out | input | WIDTH | Bus output value when the bus owns the port |
| pad_in | input | WIDTH | Pad input levels (asynchronous) |
| pad_oe | output | WIDTH | Per-pin pad output-enable |
| pad_out | output | WIDTH | Per-pin pad output value |

## Verification
The hardest case to reach is a latch write made while the pin belongs to someone else: a timer-owned pin, or the whole port during bus takeover. The write must stay invisible at the pad and then appear once ownership returns. The bench writes new data while ownership is active, checks that the pad has not changed, then releases ownership or goes back to single-chip mode and checks that the newest latch value reaches the pin and the read-back. The direction, drive and open-drain rules are swept over all 256 register values, and the expected pad values are computed arithmetically.

// File: rtl/gport_pkg.sv
// Package: shared mode encoding and the bus-takeover decode for the port slice.
// Assumes a 2-bit mode input that is stable while it is used.
package gport_pkg;

    typedef enum logic [1:0] {
        PM_SINGLE = 2'b00,
        PM_EXPAND = 2'b01,
        PM_BOOT   = 2'b10,
        PM_TEST   = 2'b11
    } port_mode_e;

    // True when the operating mode hands the bus port to the external bus.
    function automatic logic bus_owns(input logic [1:0] m);
        return (m == PM_EXPAND) || (m == PM_TEST);
    endfunction

endpackage

// File: rtl/gport_sync.sv
// Module: two-flop synchronizer, one independent chain per pad bit.
// Assumes pad_in is asynchronous to clk; adds two cycles of latency.
module gport_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_sync
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic stg1, stg2;

        // Capture the pad level in two stages to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg1 <= 1'b0;
                stg2 <= 1'b0;
            end else begin
                stg1 <= pad_in[i];
                stg2 <= stg1;
            end
        end

        assign pin_sync[i] = stg2;
    end

endmodule

// File: rtl/gport_regs.sv
// Module: data latch, direction register and registered read-back mux.
// Assumes the data register at BASE_ADDR and the direction register at BASE_ADDR+1.
module gport_regs #(
    parameter int WIDTH     = 8,
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  dat_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(BASE_ADDR + 1);

    logic [WIDTH-1:0] rd_mux;

    // Register writes: the latch is updated regardless of pin ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            if (addr == DAT_ADDR) dat_q <= wdata;
            if (addr == DIR_ADDR) dir_q <= wdata;
        end
    end

    // Read selection: outputs show the latch, inputs show the synchronized pad.
    always_comb begin
        if (addr == DAT_ADDR)      rd_mux = (dir_q & dat_q) | (~dir_q & pin_sync);
        else if (addr == DIR_ADDR) rd_mux = dir_q;
        else                       rd_mux = '0;
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dat_q == '0) && (dir_q == '0) && (rdata == '0));

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == DAT_ADDR) |=> (dat_q == $past(wdata)));

    // R3
    input_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == DAT_ADDR && dir_q == '0) |=> (rdata == $past(pin_sync)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/gport_drive.sv
// Module: per-pin pad drive selection covering bus takeover, timer ownership,
// direction and the open-drain option. Priority: bus > timer > direction.
// Assumes pad_out is forced to 0 on every undriven pin.
module gport_drive
    import gport_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter bit IS_BUS_PORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             od_en,
    input  logic [WIDTH-1:0] dat_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] tmr_own,
    input  logic [WIDTH-1:0] tmr_val,
    input  logic [WIDTH-1:0] bus_oe,
    input  logic [WIDTH-1:0] bus_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);

    logic             bus_take;
    logic             od_eff;
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] want;

    if (IS_BUS_PORT) begin : g_bus
        assign bus_take = bus_owns(mode);
    end else begin : g_nobus
        assign bus_take = 1'b0;
    end

    // Open-drain is honoured only while the port is not carrying the bus.
    always_comb od_eff = od_en && !bus_take;

    // Value source and drive request per pin: timer first, then latch/direction.
    always_comb begin
        src  = (tmr_own & tmr_val) | (~tmr_own & dat_q);
        want = tmr_own | dir_q;
    end

    // Final pad drive per pin.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            if (bus_take) begin
                pad_oe[i]  = bus_oe[i];
                pad_out[i] = bus_out[i] & bus_oe[i];
            end else if (od_eff) begin
                pad_oe[i]  = want[i] & ~src[i];
                pad_out[i] = 1'b0;
            end else begin
                pad_oe[i]  = want[i];
                pad_out[i] = src[i] & want[i];
            end
        end
    end

    // R4
    input_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_take && tmr_own == '0) |-> ((pad_oe & ~dir_q) == '0));

    // R5
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        od_eff |-> (pad_out == '0));

    // R7
    timer_pin_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_take && $stable(tmr_own) && $stable(tmr_val) && $stable(od_en)
         && $stable(mode)) |-> $stable(pad_out & tmr_own));

endmodule

// File: rtl/gport_slice.sv
// Module: top of the bidirectional port slice. Ties the synchronizer,
// the register file and the pad drive logic together.
// Assumes a single clock domain for the register bus; pad_in is asynchronous.
module gport_slice #(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 4,
    parameter int BASE_ADDR   = 0,
    parameter bit IS_BUS_PORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    input  logic [1:0]        mode,
    input  logic              od_en,
    input  logic [WIDTH-1:0]  tmr_own,
    input  logic [WIDTH-1:0]  tmr_val,
    input  logic [WIDTH-1:0]  bus_oe,
    input  logic [WIDTH-1:0]  bus_out,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out
);

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dat_q;
    logic [WIDTH-1:0] dir_q;

    gport_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pin_sync (pin_sync)
    );

    gport_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .pin_sync (pin_sync),
        .dat_q    (dat_q),
        .dir_q    (dir_q),
        .rdata    (rdata)
    );

    gport_drive #(.WIDTH(WIDTH), .IS_BUS_PORT(IS_BUS_PORT)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .od_en   (od_en),
        .dat_q   (dat_q),
        .dir_q   (dir_q),
        .tmr_own (tmr_own),
        .tmr_val (tmr_val),
        .bus_oe  (bus_oe),
        .bus_out (bus_out),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

endmodule

// File: tb/gport_slice_tb.sv
module gport_slice_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic [1:0]    mode = 2'b00;
    logic          od_en = 1'b0;
    logic [W-1:0]  tmr_own = '0;
    logic [W-1:0]  tmr_val = '0;
    logic [W-1:0]  bus_oe = '0;
    logic [W-1:0]  bus_out = '0;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_oe;
    logic [W-1:0]  pad_out;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    gport_slice #(.WIDTH(W), .ADDR_W(AW), .BASE_ADDR(0), .IS_BUS_PORT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .mode(mode), .od_en(od_en),
        .tmr_own(tmr_own), .tmr_val(tmr_val), .bus_oe(bus_oe), .bus_out(bus_out),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        rd(4'd1, rd_val); check("R1 dir", rd_val, 8'h00);
        rd(4'd0, rd_val); check("R1 data", rd_val, 8'h00);

        // R9 direction read-back and unmapped address
        wr(4'd1, 8'h3C);
        rd(4'd1, rd_val); check("R9 dir", rd_val, 8'h3C);
        wr(4'd7, 8'hFF);
        rd(4'd7, rd_val); check("R9 unmapped", rd_val, 8'h00);
        rd(4'd1, rd_val); check("R9 dir after unmapped write", rd_val, 8'h3C);

        // R2 + R3 mixed read-back over several pad patterns
        wr(4'd0, 8'hA5);
        for (int k = 0; k < 16; k++) begin
            logic [W-1:0] p;
            p = W'(k * 17 + 3);
            @(negedge clk); pad_in = p;
            repeat (2) @(negedge clk);
            rd(4'd0, rd_val);
            check("R2/R3 mixed read", rd_val, (8'h3C & 8'hA5) | (~8'h3C & p));
        end

        // R10 rdata holds without a read strobe
        pad_in = 8'h00;
        repeat (5) @(negedge clk);
        check("R10 hold", rdata, (8'h3C & 8'hA5) | (~8'h3C & W'(15 * 17 + 3)));

        // R4 push-pull sweep over every direction value
        for (int d = 0; d < 256; d++) begin
            wr(4'd1, W'(d));
            wr(4'd0, W'(d) ^ 8'h5A);
            check("R4 oe", pad_oe, W'(d));
            check("R4 out", pad_out, (W'(d) ^ 8'h5A) & W'(d));
        end

        // R2 latch written while pins are inputs
        wr(4'd1, 8'h00);
        wr(4'd0, 8'hC3);
        check("R4 inputs undriven", pad_oe, 8'h00);
        wr(4'd1, 8'hFF);
        rd(4'd0, rd_val); check("R2 latch kept for inputs", rd_val, 8'hC3);

        // R5 open-drain sweep in single-chip mode
        od_en = 1'b1;
        for (int v = 0; v < 256; v++) begin
            wr(4'd0, W'(v));
            check("R5 oe", pad_oe, ~W'(v));
            check("R5 out", pad_out, 8'h00);
        end
        // R5/R6 open-drain also in bootstrap mode, masked by direction
        mode = 2'b10;
        wr(4'd1, 8'h0F);
        wr(4'd0, 8'h35);
        check("R6 boot od oe", pad_oe, 8'h0A);
        check("R6 boot od out", pad_out, 8'h00);

        // R6 bus takeover in expanded mode: od and timer ignored
        mode = 2'b01; bus_oe = 8'hF0; bus_out = 8'hA5; tmr_own = 8'h0F; tmr_val = 8'h0F;
        @(negedge clk);
        check("R6 expand oe", pad_oe, 8'hF0);
        check("R6 expand out", pad_out, 8'hA0);
        mode = 2'b11; bus_oe = 8'h3C; bus_out = 8'hFF;
        @(negedge clk);
        check("R6 test oe", pad_oe, 8'h3C);
        check("R6 test out", pad_out, 8'h3C);
        // R2 writes during bus takeover land in the latch
        wr(4'd0, 8'h99);
        check("R6 write hidden oe", pad_oe, 8'h3C);
        check("R6 write hidden out", pad_out, 8'h3C);
        mode = 2'b00; od_en = 1'b0; tmr_own = 8'h00; wr(4'd1, 8'hFF);
        check("R2 latch after bus", pad_out, 8'h99);
        rd(4'd0, rd_val); check("R2 read after bus", rd_val, 8'h99);

        // R7 timer ownership
        wr(4'd1, 8'h00);
        tmr_own = 8'h0F; tmr_val = 8'h05;
        @(negedge clk);
        check("R7 oe", pad_oe, 8'h0F);
        check("R7 out", pad_out, 8'h05);
        wr(4'd0, 8'hFF);
        check("R7 write ignored oe", pad_oe, 8'h0F);
        check("R7 write ignored out", pad_out, 8'h05);
        wr(4'd1, 8'hF0);
        check("R7 mixed oe", pad_oe, 8'hFF);
        check("R7 mixed out", pad_out, 8'hF5);

        // R8 release returns pins to direction and latest latch
        tmr_own = 8'h00;
        @(negedge clk);
        check("R8 oe", pad_oe, 8'hF0);
        check("R8 out", pad_out, 8'hF0);
        wr(4'd1, 8'hFF);
        check("R8 latest latch", pad_out, 8'hFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule